// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent virtual-to-physical page translations for a memory management unit. A lookup presents a virtual page number. The block compares that number against the tag of every valid entry in the same cycle. One cycle later it returns a registered response. On a hit, the response carries the stored physical page number together with a read-only flag and a user-access flag. On a miss, the response says so, and the surrounding logic runs the page walk elsewhere.

When the walk finishes, the resulting translation is written back through the fill port. A fill for a page that is already cached rewrites that entry in place. Otherwise the fill takes the lowest-numbered empty entry. When no entry is empty, the fill evicts the entry named by a round-robin pointer. Writing the page-table base register empties the whole cache, as happens on a context switch. A separate invalidate command removes only the entry whose virtual page matches a supplied value.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is empty, rsp_valid is 0, and the first lookup misses.
- R2: rsp_valid is 1 exactly in the cycle after a cycle with lk_valid high, and 0 otherwise.
- R3: A lookup whose virtual page matches a valid entry returns rsp_hit=1 with that entry's physical page number, read-only flag and user flag.
- R4: A lookup that matches no valid entry returns rsp_hit=0, with rsp_ppn, rsp_ro and rsp_user all 0.
- R5: Up to ENTRIES fills of distinct virtual pages into an empty cache are all kept and all hit afterwards.
- R6: With the cache full, a fill of a new page evicts entries in round-robin order. The pointer is 0 after reset and advances by one, wrapping, only on such an eviction. The first eviction after filling entries 0..15 in order removes the page filled first.
- R7: A fill whose virtual page is already cached overwrites that entry. It evicts nothing and leaves the round-robin pointer unchanged.
- R8: A cycle with ptbase_wr high empties every entry from the next cycle on. A lookup made in that same cycle still sees the contents from before the flush.
- R9: An invalidate removes only the entry whose virtual page equals inv_vpn. An invalidate that matches nothing has no effect.
- R10: A fill presented in the same cycle as ptbase_wr is discarded.
- R11: An entry freed by an invalidate is reused by the next fill of a new page, and no valid entry is evicted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_ro | input | 1 | Read-only flag of the fill |
| fill_user | input | 1 | User-access flag of the fill |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Virtual page to invalidate |
| ptbase_wr | input | 1 | Page-table base written: empty all entries |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Physical page on hit, 0 on miss |
| rsp_ro | output | 1 | Read-only flag on hit |
| rsp_user | output | 1 | User-access flag on hit |

## Verification
A corrupted valid bit, tag or replacement pointer does not show at the ports until a lookup touches the affected page. The bench therefore follows every fill, eviction, invalidate and flush with lookups of both the affected page and its neighbours. A wrong round-robin pointer shows only at the next eviction, as a miss on a page that should have survived. A stale valid bit after a flush or invalidate appears as a false hit one cycle after the lookup. Duplicate entries would break the single-match property on the next lookup of that page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic ro;
    logic user;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int VPN_W   = 36,
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          any_hit
);
  // one comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/tlb_onehot_enc.sv
module tlb_onehot_enc #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] valid,
  input  logic               hit_any,
  input  logic [IDX_W-1:0]   hit_idx,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;
  logic             replace;

  // lowest-numbered empty entry
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign slot    = hit_any ? hit_idx : (have_free ? free_idx : rr_q);
  assign replace = fill_en && !hit_any && !have_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (replace) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R11: a new page never lands on a valid entry while an empty one exists
  a_r11_free_first: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !hit_any && !(&valid)) |-> !valid[slot]);

  // R7: a refill targets an entry that is present
  a_r7_refill_present: assert property (@(posedge clk) disable iff (rst)
    (fill_en && hit_any) |-> valid[slot]);
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 40,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          inv_en,
  input  logic [ENTRIES-1:0]            inv_vec,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PPN_W-1:0]              wr_ppn,
  input  tlb_perm_t                     wr_perm,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [ENTRIES-1:0]            valid,
  output logic [ENTRIES-1:0][VPN_W-1:0] tags,
  output logic [PPN_W-1:0]              rd_ppn,
  output tlb_perm_t                     rd_perm
);
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [PPN_W-1:0]              ppn_mem  [ENTRIES];
  tlb_perm_t                     perm_mem [ENTRIES];

  always_comb begin
    valid_d = valid_q;
    if (inv_en) valid_d = valid_d & ~inv_vec;
    if (wr_en)  valid_d[wr_idx] = 1'b1;
    if (flush)  valid_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  // payload storage, no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx]    <= wr_vpn;
      ppn_mem[wr_idx]  <= wr_ppn;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  assign valid   = valid_q;
  assign tags    = tag_q;
  assign rd_ppn  = ppn_mem[rd_idx];
  assign rd_perm = perm_mem[rd_idx];

  // R8 / R10: a flush empties every entry, even with a fill in the same cycle
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));

  // R9: the matching entry is gone after an invalidate
  a_r9_inv_clears: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !wr_en && !flush) |=> ((valid_q & $past(inv_vec)) == '0));

  // R5: a fill makes its target entry valid
  a_r5_fill_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 40,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_ro,
  input  logic             fill_user,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             ptbase_wr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_ro,
  output logic             rsp_user
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0]            lk_vec, fill_vec, inv_vec;
  logic                          lk_any, fill_any, inv_any;
  logic [IDX_W-1:0]              lk_idx, fill_idx, slot;
  logic [PPN_W-1:0]              rd_ppn;
  tlb_perm_t                     rd_perm;
  tlb_perm_t                     wr_perm;

  assign wr_perm = '{ro: fill_ro, user: fill_user};

  tlb_match #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) u_lk_match (
    .tags(tags), .valid(valid), .key(lk_vpn), .hit_vec(lk_vec), .any_hit(lk_any));
  tlb_match #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) u_fill_match (
    .tags(tags), .valid(valid), .key(fill_vpn), .hit_vec(fill_vec), .any_hit(fill_any));
  tlb_match #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) u_inv_match (
    .tags(tags), .valid(valid), .key(inv_vpn), .hit_vec(inv_vec), .any_hit(inv_any));

  tlb_onehot_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_enc (.vec(lk_vec), .idx(lk_idx));
  tlb_onehot_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_fill_enc (.vec(fill_vec), .idx(fill_idx));

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .fill_en(fill_valid && !ptbase_wr), .valid(valid),
    .hit_any(fill_any), .hit_idx(fill_idx), .slot(slot));

  tlb_store #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .flush(ptbase_wr),
    .inv_en(inv_valid && inv_any), .inv_vec(inv_vec),
    .wr_en(fill_valid), .wr_idx(slot), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
    .wr_perm(wr_perm), .rd_idx(lk_idx),
    .valid(valid), .tags(tags), .rd_ppn(rd_ppn), .rd_perm(rd_perm));

  // registered response, one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_ro    <= 1'b0;
      rsp_user  <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any;
      rsp_ppn   <= (lk_valid && lk_any) ? rd_ppn : '0;
      rsp_ro    <= lk_valid && lk_any && rd_perm.ro;
      rsp_user  <= lk_valid && lk_any && rd_perm.user;
    end
  end

  // R2: response strobe follows the request by one cycle
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  // R4: a miss carries no translation
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && !rsp_ro && !rsp_user));

  // R7: never two valid entries for one page
  a_r7_no_dup: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec));

  // R1: a hit is only reported with a response
  a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int VPN_W = 36;
  localparam int PPN_W = 40;

  logic             clk = 1'b0;
  logic             rst;
  logic             lk_valid, fill_valid, inv_valid, ptbase_wr;
  logic [VPN_W-1:0] lk_vpn, fill_vpn, inv_vpn;
  logic [PPN_W-1:0] fill_ppn;
  logic             fill_ro, fill_user;
  logic             rsp_valid, rsp_hit, rsp_ro, rsp_user;
  logic [PPN_W-1:0] rsp_ppn;

  int nchecks = 0;
  int nfail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  tlb_fa #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(16)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_ro(fill_ro), .fill_user(fill_user), .inv_valid(inv_valid),
    .inv_vpn(inv_vpn), .ptbase_wr(ptbase_wr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_ro(rsp_ro), .rsp_user(rsp_user));

  function automatic logic [VPN_W-1:0] vpn_of(input int i);
    return VPN_W'(36'h9_0000_1000 + i * 7);
  endfunction
  function automatic logic [PPN_W-1:0] ppn_of(input int i);
    return PPN_W'(40'h55_000A_0000 + i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic lookup(input logic [VPN_W-1:0] v, input bit eh,
                        input logic [PPN_W-1:0] ep, input bit ero, input bit eu,
                        input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit == eh, {req, " hit"}, 64'(rsp_hit), 64'(eh));
    chk(rsp_ppn == (eh ? ep : '0), {req, " ppn"}, 64'(rsp_ppn), 64'(eh ? ep : '0));
    chk({rsp_ro, rsp_user} == (eh ? {ero, eu} : 2'b00), {req, " perm"},
        64'({rsp_ro, rsp_user}), 64'(eh ? {ero, eu} : 2'b00));
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                      input bit ro, input bit us);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_ro = ro; fill_user = us;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic invalidate(input logic [VPN_W-1:0] v);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = v;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 idle after reset", 64'(rsp_valid), 64'd0);
    lookup(vpn_of(0), 1'b0, '0, 1'b0, 1'b0, "R1 empty miss");
    lookup(vpn_of(3), 1'b0, '0, 1'b0, 1'b0, "R4 miss zero");
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < 16; i++) fill(vpn_of(i), ppn_of(i), i[0], i[1]);
    for (int i = 0; i < 16; i++) lookup(vpn_of(i), 1'b1, ppn_of(i), i[0], i[1], "R5 R3 kept");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 strobe drops", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_replace();
    fill(36'h100, 40'h1100, 1'b1, 1'b0);
    lookup(vpn_of(0), 1'b0, '0, 1'b0, 1'b0, "R6 first evicted");
    lookup(vpn_of(1), 1'b1, ppn_of(1), 1'b1, 1'b0, "R6 second kept");
    lookup(36'h100, 1'b1, 40'h1100, 1'b1, 1'b0, "R6 new present");
    fill(36'h101, 40'h1101, 1'b1, 1'b0);
    lookup(vpn_of(1), 1'b0, '0, 1'b0, 1'b0, "R6 second evicted");
    lookup(vpn_of(2), 1'b1, ppn_of(2), 1'b0, 1'b1, "R6 third kept");
  endtask

  task automatic t_refill();
    fill(vpn_of(5), 40'h77_7777, 1'b0, 1'b1);
    lookup(vpn_of(5), 1'b1, 40'h77_7777, 1'b0, 1'b1, "R7 overwritten");
    lookup(vpn_of(2), 1'b1, ppn_of(2), 1'b0, 1'b1, "R7 no eviction");
    lookup(36'h100, 1'b1, 40'h1100, 1'b1, 1'b0, "R7 no eviction b");
    fill(36'h102, 40'h1102, 1'b1, 1'b0);
    lookup(vpn_of(2), 1'b0, '0, 1'b0, 1'b0, "R7 pointer unchanged");
    lookup(vpn_of(3), 1'b1, ppn_of(3), 1'b1, 1'b1, "R7 next kept");
  endtask

  task automatic t_invalidate();
    invalidate(vpn_of(7));
    lookup(vpn_of(7), 1'b0, '0, 1'b0, 1'b0, "R9 target removed");
    lookup(vpn_of(8), 1'b1, ppn_of(8), 1'b0, 1'b0, "R9 neighbour kept");
    invalidate(36'h999);
    lookup(vpn_of(8), 1'b1, ppn_of(8), 1'b0, 1'b0, "R9 nonmatch no effect");
    lookup(vpn_of(6), 1'b1, ppn_of(6), 1'b0, 1'b1, "R9 nonmatch no effect b");
    fill(36'h103, 40'h1103, 1'b0, 1'b0);
    lookup(36'h103, 1'b1, 40'h1103, 1'b0, 1'b0, "R11 reuse hit");
    lookup(vpn_of(3), 1'b1, ppn_of(3), 1'b1, 1'b1, "R11 no eviction");
    lookup(36'h101, 1'b1, 40'h1101, 1'b1, 1'b0, "R11 no eviction b");
  endtask

  task automatic t_flush();
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn_of(3); ptbase_wr = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; ptbase_wr = 1'b0;
    chk(rsp_hit == 1'b1, "R8 same-cycle old view", 64'(rsp_hit), 64'd1);
    chk(rsp_ppn == ppn_of(3), "R8 same-cycle ppn", 64'(rsp_ppn), 64'(ppn_of(3)));
    lookup(vpn_of(3), 1'b0, '0, 1'b0, 1'b0, "R8 flushed");
    lookup(36'h100, 1'b0, '0, 1'b0, 1'b0, "R8 flushed b");
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 36'h200; fill_ppn = 40'h2200;
    fill_ro = 1'b0; fill_user = 1'b1; ptbase_wr = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; ptbase_wr = 1'b0;
    lookup(36'h200, 1'b0, '0, 1'b0, 1'b0, "R10 fill discarded");
    fill(36'h300, 40'h3300, 1'b1, 1'b1);
    lookup(36'h300, 1'b1, 40'h3300, 1'b1, 1'b1, "R5 fill after flush");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
    ptbase_wr = 1'b0; lk_vpn = '0; fill_vpn = '0; fill_ppn = '0;
    fill_ro = 1'b0; fill_user = 1'b0; inv_vpn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_all();
    t_replace();
    t_refill();
    t_invalidate();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule